// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sequences a battery-backed memory array through power loss and return. Three comparator results describe the supply: above the write-protect trip level, above the battery voltage, and above the level at which the array supply is moved onto the battery. All three are synchronized to a free-running clock. From them the block decides when the host's chip-enable, write-enable and output-enable strobes may reach the array, which source powers the array, when the charger runs, and when a host reset is requested.

When the supply drops below the trip level, the array is cut off from the host at once. After the supply returns, access is granted only once the trip comparator has stayed high for a programmable recovery count. A longer reset timeout follows the same restart rule. The reset request is an active-low open-drain style signal. It is modelled as a pull-low enable that is never driven high, and it is let go entirely once the supply falls below the battery. A one-shot seal keeps the battery disconnected from a freshly reset block until the supply first reaches the trip level.

Top module: `pfail_supervisor`

## Requirements
- R1: While the synchronized trip comparator is low, mem_ce_n and mem_we_n are 1 and mem_dq_drive is 0, whatever the host strobes are.
- R2: Access (mem_*_n following the host) starts exactly SYNC_STAGES + REC_CYCLES clock edges after the first edge that samples cmp_trip high, provided cmp_trip stays high throughout.
- R3: While access is granted, mem_ce_n, mem_we_n and mem_oe_n equal the host strobes. mem_dq_drive is 1 only when host_ce_n=0, host_oe_n=0 and host_we_n=1. While access is not granted, mem_oe_n is 1.
- R4: Any cycle with cmp_trip low restarts both the recovery count and the reset timeout count from zero.
- R5: While the synchronized battery comparator is high, rst_pull_low is 1 within SYNC_STAGES edges of cmp_trip going low.
- R6: rst_pull_low is 0 whenever the synchronized battery comparator is low, so the reset is held through power-down only until the supply falls below the battery.
- R7: On power-up, rst_pull_low falls to 0 exactly SYNC_STAGES + max(RST_CYCLES, REC_CYCLES+1) edges after the first edge that samples cmp_trip high.
- R8: rst_pull_low never falls to 0 while the battery comparator is high and access is still withheld.
- R9: src_mains follows the synchronized switchover comparator. src_batt is 1 only when that comparator is low and backup is enabled. The two are never both 1.
- R10: After rst_n, backup is sealed and src_batt stays 0. The seal opens one edge after the synchronized trip comparator is first seen high, and it stays open until the next rst_n.
- R11: charge_en equals the synchronized trip comparator.
- R12: During and right after rst_n, all memory strobes are inactive, and mem_dq_drive, src_mains, src_batt, charge_en and rst_pull_low are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_trip | input | 1 | Supply above write-protect trip level |
| cmp_switch | input | 1 | Supply above battery switchover level |
| cmp_batt | input | 1 | Supply above battery voltage |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the array |
| mem_we_n | output | 1 | Gated write enable to the array |
| mem_oe_n | output | 1 | Gated output enable to the array |
| mem_dq_drive | output | 1 | Enable for the array data drivers (0 = high impedance) |
| src_mains | output | 1 | Array powered from the external supply |
| src_batt | output | 1 | Array powered from the battery |
| charge_en | output | 1 | Battery charger enable |
| rst_pull_low | output | 1 | 1 = pull the open-drain reset line low |

## Verification
The properties assume that the comparator inputs come from one falling or rising supply. They allow any ordering of the three levels, but the reset-before-access property only claims something while the battery comparator is high. The stimulus walks a single supply level through four bands (below switchover, above switchover, above battery, above trip), so the comparators always stay consistent with one another. It includes single-cycle dips below the trip level during both the recovery count and the reset timeout. The host strobes step through all eight combinations continuously, so every band and every phase of the counts meets every strobe pattern.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef struct packed {
    logic trip;
    logic sw;
    logic bat;
  } sense_t;

  function automatic int unsigned pfs_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    logic [W-1:0] r;
    logic [W-1:0] r_d;
    if (g == 0) begin : g_first
      assign r_d = d;
    end else begin : g_chain
      assign r_d = g_st[g-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else        r <= r_d;
    end
  end

  assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/pfs_window.sv
module pfs_window #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          en;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    en     = 1'b0;
    if (!run) begin
      en     = done_q | (cnt_q != '0);
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      en = 1'b1;
      if (cnt_q == LAST) done_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_done_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && run) |=> done_q);
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!done_q && cnt_q == '0));

endmodule

// File: rtl/pfs_gate.sv
module pfs_gate (
  input  logic ok,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic mem_dq_drive
);

  always_comb begin
    mem_ce_n     = host_ce_n | ~ok;
    mem_we_n     = host_we_n | ~ok;
    mem_oe_n     = host_oe_n | ~ok;
    mem_dq_drive = ok & ~host_ce_n & ~host_oe_n & host_we_n;
  end

endmodule

// File: rtl/pfail_supervisor.sv
module pfail_supervisor #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REC_CYCLES  = 250000,
  parameter int unsigned RST_CYCLES  = 700000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_trip,
  input  logic cmp_switch,
  input  logic cmp_batt,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic mem_dq_drive,
  output logic src_mains,
  output logic src_batt,
  output logic charge_en,
  output logic rst_pull_low
);
  import pfs_pkg::*;

  localparam int unsigned TMO_EFF = pfs_max(RST_CYCLES, REC_CYCLES + 1);

  sense_t sense;
  logic   rec_done, tmo_done;
  logic   access_ok;
  logic   sealed_q, sealed_d, seal_en;

  pfs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cmp_trip, cmp_switch, cmp_batt}),
    .q     (sense)
  );

  pfs_window #(.LIMIT(REC_CYCLES)) u_rec (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (sense.trip),
    .done  (rec_done)
  );

  pfs_window #(.LIMIT(TMO_EFF)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (sense.trip),
    .done  (tmo_done)
  );

  // access follows the synchronized comparator directly so protection is not delayed by a counter register
  assign access_ok = rec_done & sense.trip;

  pfs_gate u_gate (
    .ok           (access_ok),
    .host_ce_n    (host_ce_n),
    .host_we_n    (host_we_n),
    .host_oe_n    (host_oe_n),
    .mem_ce_n     (mem_ce_n),
    .mem_we_n     (mem_we_n),
    .mem_oe_n     (mem_oe_n),
    .mem_dq_drive (mem_dq_drive)
  );

  // shipping seal: opens once on the first good supply
  always_comb begin
    seal_en  = sealed_q & sense.trip;
    sealed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sealed_q <= 1'b1;
    else if (seal_en) sealed_q <= sealed_d;
  end

  always_comb begin
    src_mains    = sense.sw;
    src_batt     = ~sense.sw & ~sealed_q;
    charge_en    = sense.trip;
    rst_pull_low = sense.bat & ~(tmo_done & sense.trip);
  end

  p_wp_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sense.trip |-> (mem_ce_n && mem_we_n && !mem_dq_drive));
  p_rst_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sense.bat && !sense.trip) |-> rst_pull_low);
  p_rst_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sense.bat |-> !rst_pull_low);
  p_access_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sense.bat && !rst_pull_low) |-> access_ok);
  p_src_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_mains && src_batt));
  p_seal_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sealed_q |=> !sealed_q);

endmodule

// File: tb/pfail_supervisor_bench.sv
module pfail_supervisor_bench;

  localparam int unsigned SYNC = 2;
  localparam int unsigned REC  = 6;
  localparam int unsigned RST  = 10;
  localparam int unsigned TMO  = (RST > REC + 1) ? RST : REC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_trip = 1'b0, cmp_switch = 1'b0, cmp_batt = 1'b0;
  logic host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive;
  logic src_mains, src_batt, charge_en, rst_pull_low;

  int errors = 0;
  int checks = 0;

  // bench model state
  bit d1t, d1s, d1b, ts, ss, bs;
  bit sealed_m = 1'b1;
  int hi = 0;
  int unsigned hs = 0;

  always #4 clk = ~clk;

  pfail_supervisor #(.SYNC_STAGES(SYNC), .REC_CYCLES(REC), .RST_CYCLES(RST)) u_pfail_supervisor (
    .clk(clk), .rst_n(rst_n),
    .cmp_trip(cmp_trip), .cmp_switch(cmp_switch), .cmp_batt(cmp_batt),
    .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_drive(mem_dq_drive), .src_mains(src_mains), .src_batt(src_batt),
    .charge_en(charge_en), .rst_pull_low(rst_pull_low)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit ok;
    ok = ts && (hi >= int'(REC));
    chk(mem_ce_n, host_ce_n | !ok, ok ? "R3" : "R1", "mem_ce_n");
    chk(mem_we_n, host_we_n | !ok, ok ? "R3" : "R1", "mem_we_n");
    chk(mem_oe_n, host_oe_n | !ok, "R3", "mem_oe_n");
    chk(mem_dq_drive, ok & !host_ce_n & !host_oe_n & host_we_n, ok ? "R3" : "R1", "mem_dq_drive");
    chk(rst_pull_low, bs && !(ts && hi >= int'(TMO)), bs ? "R7" : "R6", "rst_pull_low");
    chk(src_mains, ss, "R9", "src_mains");
    chk(src_batt, !ss && !sealed_m, "R10", "src_batt");
    chk(charge_en, ts, "R11", "charge_en");
  endtask

  // level: 0 below all, 1 above switchover, 2 above battery, 3 above trip
  task automatic set_level(input int lv);
    cmp_switch = (lv >= 1);
    cmp_batt   = (lv >= 2);
    cmp_trip   = (lv >= 3);
  endtask

  task automatic step();
    @(posedge clk);
    hi       = ts ? hi + 1 : 0;          // R4: restart on any low cycle
    sealed_m = sealed_m & !ts;
    ts = d1t; ss = d1s; bs = d1b;
    d1t = cmp_trip; d1s = cmp_switch; d1b = cmp_batt;
    #1;
    check_all();
    hs = hs + 1;
    {host_ce_n, host_we_n, host_oe_n} = 3'(hs);
  endtask

  task automatic hold(input int lv, input int n);
    set_level(lv);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    // R12: reset state
    set_level(3);
    repeat (3) @(posedge clk);
    #1;
    chk(mem_ce_n, 1'b1, "R12", "mem_ce_n in reset");
    chk(mem_we_n, 1'b1, "R12", "mem_we_n in reset");
    chk(mem_oe_n, 1'b1, "R12", "mem_oe_n in reset");
    chk(mem_dq_drive, 1'b0, "R12", "mem_dq_drive in reset");
    chk(src_mains | src_batt, 1'b0, "R12", "source in reset");
    chk(charge_en, 1'b0, "R12", "charge_en in reset");
    chk(rst_pull_low, 1'b0, "R12", "rst_pull_low in reset");
    set_level(0);
    rst_n = 1'b1;
    hold(0, 4);
    hold(1, 5);   // R9 mains via switchover, still sealed
    hold(0, 5);   // R10 sealed: no battery path
    hold(2, 6);   // R5/R6 reset held once above battery
    hold(3, 20);  // R2 R7 R8 R10 R11 power-up
    hold(2, 4);
    hold(3, 4);
    hold(2, 1);   // R4 dip during recovery
    hold(3, 20);
    hold(2, 6);
    hold(3, REC + SYNC + 1); // inside reset timeout, access already granted
    hold(2, 1);   // R4 dip during timeout
    hold(3, 20);
    hold(1, 6);   // R6 reset released below battery
    hold(0, 6);   // R10 battery now connected
    hold(3, 20);
    hold(0, 3);
    hold(3, 24);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule